// File: doc/BRIEF.md
# Three-Level H-Bridge Sine PWM Controller

This block drives the four gates of a single-phase, two-leg H-bridge so that the bridge output takes three levels and follows a sine wave. A sine table with one entry per switching period supplies the reference. The entry is chosen at the start of each switching period and held for the whole of it, which gives regular-sampled symmetric modulation. An up/down carrier counter turns the held sample into an on-time that is centred in the switching period, so both edges of each pulse move.

A two-bit input picks one of three ways of sharing the work between the two legs:
- **Bipolar:** both legs switch at the carrier rate and the output ripple runs at twice the carrier frequency.
- **Mixed:** one leg switches at the carrier rate and the other flips once per half of the fundamental.
- **Alternating:** the legs take turns. One leg is modulated while the other is parked, and the roles swap each half of the fundamental.

A modulation index scales the amplitude. Every rising gate edge is delayed by a fixed dead time. The scheme and the enable are only picked up at the start of a fundamental period. While the block is disabled, all four gates are held off.

Top module: `hbridge_pwm3`

## Requirements
- R1: A switching period lasts 2·PERIOD clock cycles. `sample_strobe` pulses for exactly one cycle at the start of every switching period, once the first period after reset is over. Table entry k (0..SAMPLES-1) is used for the whole of the k-th period of each fundamental, and the reference value is sin(2πk/SAMPLES).
- R2: For a compare value C (0..PERIOD), the raw high-side request of a leg is on for 2·C cycles centred in its switching period. With C = 0 it is fully off; with C = PERIOD it is fully on.
- R3: Scheme code 0 (bipolar), with m = mod_index/2^M_W and s = sin(2πk/SAMPLES):
  - leg-1 compare is PERIOD·(0.5 + 0.5·m·s);
  - leg-2 compare is PERIOD·(0.5 − 0.5·m·s).
- R4: Scheme code 1 (mixed):
  - leg-1 compare is PERIOD·m·s for k < SAMPLES/2 and PERIOD·(1 + m·s) otherwise;
  - leg-2 compare is 0 for k < SAMPLES/2 and PERIOD otherwise.
- R5: Scheme codes 2 and 3 (alternating):
  - for k < SAMPLES/2, leg 1 uses PERIOD·m·s and leg 2 is held at 0;
  - otherwise leg 1 is held at 0 and leg 2 uses PERIOD·m·|s|.
- R6: Each low-side gate is the complement of its leg's high-side request. Every rising gate edge is delayed by DEAD cycles. The high and low gates of one leg are never on in the same cycle.
- R7: `mod_index` and the table sample are captured only at the start of a switching period. A change inside a period has no effect until the next period.
- R8: Compare values are saturated to 0..PERIOD. At full-scale `mod_index` the on-time never exceeds the switching period.
- R9: `scheme` and `enable` are captured only at the start of a fundamental period, which is the period that uses table entry 0.
- R10: While the captured enable is low, all four gates are off, at most 3 cycles after the fundamental boundary where it was captured.
- R11: During and right after reset, all gates and `sample_strobe` are low. The enable captured at reset is low, so the gates stay off until the first fundamental boundary.

Each gate also has a small fixed latency after its request (see R6). On the cycles of a period, the period starts when `sample_strobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request, captured at fundamental boundaries |
| scheme | input | 2 | Leg-control scheme: 0 bipolar, 1 mixed, 2 or 3 alternating |
| mod_index | input | M_W | Modulation index, unsigned fraction mod_index/2^M_W |
| gate_h1 | output | 1 | Leg-1 high-side gate command |
| gate_l1 | output | 1 | Leg-1 low-side gate command |
| gate_h2 | output | 1 | Leg-2 high-side gate command |
| gate_l2 | output | 1 | Leg-2 low-side gate command |
| sample_strobe | output | 1 | One-cycle pulse at the start of each switching period |

## Verification
The hardest situation to reach from the ports is an input change that lands at an awkward time. For `mod_index`, that means a change inside a switching period. For `scheme` and `enable`, it means a change part-way through a fundamental, where the new value must wait for the next table wrap.

The stimulus moves `mod_index` on a drifting random cadence, so changes land at every phase of the carrier. It switches `scheme` and `enable` in the middle of a fundamental. The expected duty of each period is built from the values the bench saw at the period and fundamental boundaries. A design that used the live values would therefore mismatch in whole windows of pulses.

Directed fundamentals cover zero and full-scale index, scheme code 3, and a disabled stretch.

// File: rtl/hb3_pkg.sv
// hb3_pkg: shared types and elaboration-time helpers for the H-bridge PWM.
// Assumes callers pass a positive half-table size.
package hb3_pkg;

    // Leg-control scheme codes; code 3 aliases the alternating scheme.
    typedef enum logic [1:0] {
        SCH_BIPOLAR   = 2'd0,
        SCH_MIXED     = 2'd1,
        SCH_ALT       = 2'd2,
        SCH_ALT_ALIAS = 2'd3
    } scheme_e;

    // Rational sine approximation over one half-wave: position u of half, scaled to full.
    function automatic longint sine_mag(input longint u, input longint half, input longint full);
        longint p;
        p = u * (half - u);
        return (full * 16 * p) / (5 * half * half - 4 * p);
    endfunction

endpackage

// File: rtl/hb3_sine_rom.sv
// hb3_sine_rom: half-wave sine magnitude table with a sign flag.
// Assumes SAMPLES is a power of two, at least 4. The upper half of the
// address space reuses the lower half and flags the negative half-wave.
module hb3_sine_rom #(
    parameter int SAMPLES = 512,
    parameter int SIN_W   = 12,
    localparam int IDX_W  = $clog2(SAMPLES),
    localparam int HALF   = SAMPLES / 2
) (
    input  logic [IDX_W-1:0] addr,
    output logic [SIN_W-1:0] mag,
    output logic             neg
);
    import hb3_pkg::*;

    localparam longint FULL = longint'(2 ** SIN_W - 1);

    logic [SIN_W-1:0] rom [HALF];

    // Fill every table entry from the elaboration-time approximation.
    for (genvar g = 0; g < HALF; g++) begin : g_rom
        assign rom[g] = SIN_W'(sine_mag(longint'(g), longint'(HALF), FULL));
    end

    // Look up the magnitude and flag the negative half-wave.
    assign neg = addr[IDX_W-1];
    assign mag = rom[addr[IDX_W-2:0]];

endmodule

// File: rtl/hb3_carrier.sv
// hb3_carrier: center-aligned up/down carrier and table-index sequencer.
// Counts 0..PERIOD-1 up, then PERIOD-1..0 down, which gives 2*PERIOD cycles
// per switching period. The index advances at each period end.
module hb3_carrier #(
    parameter int PERIOD  = 1328,
    parameter int SAMPLES = 512,
    localparam int CNT_W  = $clog2(PERIOD + 1),
    localparam int IDX_W  = $clog2(SAMPLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic [IDX_W-1:0] idx,
    output logic             period_end,
    output logic             wrap,
    output logic             strobe
);
    logic dir_dn;

    assign period_end = dir_dn && (cnt == '0);
    assign wrap       = period_end && (idx == IDX_W'(SAMPLES - 1));

    // Step the carrier and advance the table index at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_dn <= 1'b0;
            idx    <= '0;
        end else if (!dir_dn) begin
            if (cnt == CNT_W'(PERIOD - 1)) dir_dn <= 1'b1;
            else                           cnt    <= cnt + 1'b1;
        end else if (cnt == '0) begin
            dir_dn <= 1'b0;
            idx    <= idx + 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // Flag the first cycle of each new switching period.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe <= 1'b0;
        else        strobe <= period_end;
    end

endmodule

// File: rtl/hb3_duty.sv
// hb3_duty: turns a sine sample and the modulation index into the two leg
// compare values for the selected scheme, then saturates and latches them.
// Compares load only at a period end. Scheme and enable load only at a
// fundamental wrap, and the new scheme applies to the period that starts there.
module hb3_duty #(
    parameter int PERIOD  = 1328,
    parameter int SIN_W   = 12,
    parameter int M_W     = 10,
    localparam int CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             wrap,
    input  logic [1:0]       scheme_in,
    input  logic             enable_in,
    input  logic [M_W-1:0]   mod_in,
    input  logic [SIN_W-1:0] mag,
    input  logic             neg,
    output logic [CNT_W-1:0] cmp1,
    output logic [CNT_W-1:0] cmp2,
    output logic [1:0]       scheme_q,
    output logic             en_q
);
    import hb3_pkg::*;

    localparam int PW = SIN_W + M_W + CNT_W;
    localparam int SW = CNT_W + 2;
    localparam logic signed [SW-1:0] P_S    = SW'(PERIOD);
    localparam logic signed [SW-1:0] HALF_S = SW'(PERIOD / 2);

    logic [PW-1:0]          prod;
    logic signed [SW-1:0]   a_s, ha_s, l1_s, l2_s;
    logic [1:0]             sch;

    // Clamp a signed candidate into the legal compare range 0..PERIOD.
    function automatic logic [CNT_W-1:0] sat(input logic signed [SW-1:0] v);
        if (v < 0)         return '0;
        else if (v > P_S)  return CNT_W'(PERIOD);
        else               return v[CNT_W-1:0];
    endfunction

    // Form the scaled amplitude and the per-scheme leg compare candidates.
    always_comb begin
        prod = PW'(mag) * PW'(mod_in) * PW'(PERIOD);
        a_s  = SW'(prod >> (SIN_W + M_W));
        ha_s = SW'(prod >> (SIN_W + M_W + 1));
        sch  = wrap ? scheme_in : scheme_q;
        case (scheme_e'(sch))
            SCH_BIPOLAR: begin
                l1_s = neg ? HALF_S - ha_s : HALF_S + ha_s;
                l2_s = neg ? HALF_S + ha_s : HALF_S - ha_s;
            end
            SCH_MIXED: begin
                l1_s = neg ? P_S - a_s : a_s;
                l2_s = neg ? P_S : '0;
            end
            default: begin
                l1_s = neg ? '0 : a_s;
                l2_s = neg ? a_s : '0;
            end
        endcase
    end

    // Latch the compares per period and the mode per fundamental.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp1     <= '0;
            cmp2     <= '0;
            scheme_q <= 2'd0;
            en_q     <= 1'b0;
        end else if (load) begin
            cmp1 <= sat(l1_s);
            cmp2 <= sat(l2_s);
            if (wrap) begin
                scheme_q <= scheme_in;
                en_q     <= enable_in;
            end
        end
    end

endmodule

// File: rtl/hb3_deadtime.sv
// hb3_deadtime: delays the rising edge of one gate request by DEAD cycles.
// The falling edge passes with one register of latency. Assumes the paired
// request is its complement, so the gap between two partner gates is at least DEAD.
module hb3_deadtime #(
    parameter int DEAD   = 8,
    localparam int DT_W  = $clog2(DEAD + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic gate
);
    logic [DT_W-1:0] wait_cnt;

    // Count request-high cycles and release the gate after the dead time.
    always_ff @(posedge clk) begin
        if (!rst_n || !req) begin
            wait_cnt <= '0;
            gate     <= 1'b0;
        end else if (wait_cnt == DT_W'(DEAD)) begin
            gate <= 1'b1;
        end else begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/hbridge_pwm3.sv
// hbridge_pwm3: three-level sine PWM controller for a two-leg H-bridge.
// It chains the carrier, sine table, duty computation, compare and dead-time
// stages. Assumes SAMPLES is a power of two and PERIOD is at least 2.
module hbridge_pwm3 #(
    parameter int SAMPLES = 512,
    parameter int PERIOD  = 1328,
    parameter int SIN_W   = 12,
    parameter int M_W     = 10,
    parameter int DEAD    = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic [1:0]     scheme,
    input  logic [M_W-1:0] mod_index,
    output logic           gate_h1,
    output logic           gate_l1,
    output logic           gate_h2,
    output logic           gate_l2,
    output logic           sample_strobe
);
    localparam int CNT_W = $clog2(PERIOD + 1);
    localparam int IDX_W = $clog2(SAMPLES);
    localparam logic [CNT_W:0] PER_X = (CNT_W + 1)'(PERIOD);

    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic             period_end, wrap;
    logic [SIN_W-1:0] mag;
    logic             neg;
    logic [CNT_W-1:0] cmp_l1, cmp_l2;
    logic [1:0]       scheme_q;
    logic             en_q;
    logic             on1, on2;
    logic [3:0]       req_q;
    logic [3:0]       gate_v;

    hb3_carrier #(.PERIOD(PERIOD), .SAMPLES(SAMPLES)) u_carrier (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .idx(idx),
        .period_end(period_end), .wrap(wrap), .strobe(sample_strobe)
    );

    hb3_sine_rom #(.SAMPLES(SAMPLES), .SIN_W(SIN_W)) u_rom (
        .addr(idx + 1'b1), .mag(mag), .neg(neg)
    );

    hb3_duty #(.PERIOD(PERIOD), .SIN_W(SIN_W), .M_W(M_W)) u_duty (
        .clk(clk), .rst_n(rst_n), .load(period_end), .wrap(wrap),
        .scheme_in(scheme), .enable_in(enable), .mod_in(mod_index),
        .mag(mag), .neg(neg), .cmp1(cmp_l1), .cmp2(cmp_l2),
        .scheme_q(scheme_q), .en_q(en_q)
    );

    // Center-aligned compare: on while the carrier sits in the top C counts.
    assign on1 = ({1'b0, cnt} + {1'b0, cmp_l1}) >= PER_X;
    assign on2 = ({1'b0, cnt} + {1'b0, cmp_l2}) >= PER_X;

    // Register the complementary requests, gated by the captured enable.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= {en_q & ~on2, en_q & on2, en_q & ~on1, en_q & on1};
    end

    for (genvar g = 0; g < 4; g++) begin : g_dead
        hb3_deadtime #(.DEAD(DEAD)) u_dt (
            .clk(clk), .rst_n(rst_n), .req(req_q[g]), .gate(gate_v[g])
        );
    end

    assign gate_h1 = gate_v[0];
    assign gate_l1 = gate_v[1];
    assign gate_h2 = gate_v[2];
    assign gate_l2 = gate_v[3];

endmodule

// File: rtl/hb3_checker.sv
// hb3_checker: temporal properties of hbridge_pwm3, attached by bind.
// Observes the gate ports and the latched compare and mode state.
module hb3_checker #(
    parameter int PERIOD = 1328,
    parameter int DEAD   = 8,
    parameter int CNT_W  = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate_h1,
    input logic             gate_l1,
    input logic             gate_h2,
    input logic             gate_l2,
    input logic             sample_strobe,
    input logic             period_end,
    input logic             wrap,
    input logic [CNT_W-1:0] cmp_l1,
    input logic [CNT_W-1:0] cmp_l2,
    input logic [1:0]       scheme_q,
    input logic             en_q
);
    logic [31:0] since;
    logic        armed;

    // Count cycles between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since <= '0;
            armed <= 1'b0;
        end else if (sample_strobe) begin
            since <= 32'd1;
            armed <= 1'b1;
        end else begin
            since <= since + 1'b1;
        end
    end

    AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_strobe && armed) |-> (since == 32'(2 * PERIOD))); // R1
    AST_LEG1_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_h1 && gate_l1)); // R6
    AST_LEG2_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_h2 && gate_l2)); // R6
    AST_DEAD_GAP_L1: assert property (@(posedge clk) disable iff (!rst_n)
        (DEAD > 0 && $fell(gate_h1)) |=> !gate_l1); // R6
    AST_DEAD_GAP_H2: assert property (@(posedge clk) disable iff (!rst_n)
        (DEAD > 0 && $fell(gate_l2)) |=> !gate_h2); // R6
    AST_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(period_end) |-> ($stable(cmp_l1) && $stable(cmp_l2))); // R7
    AST_CMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_l1 <= CNT_W'(PERIOD)) && (cmp_l2 <= CNT_W'(PERIOD))); // R8
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wrap) |-> ($stable(scheme_q) && $stable(en_q))); // R9
    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && $past(!en_q) && $past(!en_q, 2)) |->
        !(gate_h1 || gate_l1 || gate_h2 || gate_l2)); // R10

endmodule

bind hbridge_pwm3 hb3_checker #(.PERIOD(PERIOD), .DEAD(DEAD), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .gate_h1(gate_h1), .gate_l1(gate_l1),
    .gate_h2(gate_h2), .gate_l2(gate_l2), .sample_strobe(sample_strobe),
    .period_end(period_end), .wrap(wrap), .cmp_l1(cmp_l1), .cmp_l2(cmp_l2),
    .scheme_q(scheme_q), .en_q(en_q)
);

// File: tb/hbridge_pwm3_test.sv
// hbridge_pwm3_test: seeded random plus directed stimulus. Each switching
// period's gate on-times are compared with values from the requirement formulas.
module hbridge_pwm3_test;
    localparam int N    = 32;
    localparam int P    = 20;
    localparam int D    = 3;
    localparam int MW   = 8;
    localparam int FUND = N * 2 * P;
    localparam real PI  = 3.14159265358979;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [1:0]    scheme = 2'd0;
    logic [MW-1:0] m = '0;
    logic          gh1, gl1, gh2, gl2, strobe;

    int checks = 0, failures = 0;
    bit run_mon = 1'b0, done = 1'b0;

    hbridge_pwm3 #(.SAMPLES(N), .PERIOD(P), .SIN_W(12), .M_W(MW), .DEAD(D)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .scheme(scheme), .mod_index(m),
        .gate_h1(gh1), .gate_l1(gl1), .gate_h2(gh2), .gate_l2(gl2),
        .sample_strobe(strobe)
    );

    always #10 clk = ~clk;

    // Record one check and report a failure.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected compare value of one leg from the duty formulas (R3, R4, R5).
    function automatic real exp_cmp(input int leg, input int k, input int sch, input int mi);
        real s, mr;
        bit pos;
        s   = $sin(2.0 * PI * k / N);
        mr  = mi / 256.0;
        pos = (k < N / 2);
        case (sch)
            0: return (leg == 1) ? P * (0.5 + 0.5 * mr * s) : P * (0.5 - 0.5 * mr * s);
            1: if (leg == 1) return pos ? P * mr * s : P * (1.0 + mr * s);
               else          return pos ? 0.0 : real'(P);
            default: if (leg == 1) return pos ? P * mr * s : 0.0;
                     else          return pos ? 0.0 : -P * mr * s;
        endcase
    endfunction

    function automatic string tag(input int sch, input int mi);
        string t;
        t = (sch == 0) ? "R3,R2" : (sch == 1) ? "R4,R2" : "R5,R2";
        t = {t, ",R7,R9"};
        if (mi == 255) t = {t, ",R8"};
        return t;
    endfunction

    // Values the design captures at a clock edge.
    logic [1:0]    sch_seen;
    logic          en_seen;
    logic [MW-1:0] m_seen;
    always @(posedge clk) begin
        sch_seen <= scheme;
        en_seen  <= enable;
        m_seen   <= m;
    end

    int k_b = 0, sch_m = 0, p_k = 0, p_sch = 0, p_m = 0, since = 0;
    bit en_m = 1'b0, p_en = 1'b0, prev_en = 1'b0, win_valid = 1'b0, armed = 1'b0;
    int hi1, lo1, hi2, lo2;
    int ovl = 0, gap_err = 0, strobes = 0;
    int h1_off = 100, l1_off = 100, h2_off = 100, l2_off = 100;
    bit gh1_p = 1'b0, gl1_p = 1'b0, gh2_p = 1'b0, gl2_p = 1'b0;

    // Check one leg's on-time window against its expected compare.
    task automatic eval_leg(input int leg, input int hi, input int lo);
        real c, e;
        bit ok;
        if (!p_en) begin
            chk(hi <= 3 && lo <= 3, $sformatf("R10 leg%0d off while disabled", leg), hi + lo, 0);
            return;
        end
        c = exp_cmp(leg, p_k, p_sch, p_m);
        e = 2.0 * c - D;
        if (e < 0.0) e = 0.0;
        ok = ((hi - e) <= 4.0 && (e - hi) <= 4.0) || (c > P - 1.5 && hi >= 2 * P - D - 3);
        chk(ok, $sformatf("%s leg%0d k=%0d sch=%0d m=%0d hi-time", tag(p_sch, p_m), leg, p_k, p_sch, p_m),
            hi, int'(e));
        if (prev_en)
            chk(hi + lo >= 2 * P - 2 * D - 4 && hi + lo <= 2 * P,
                $sformatf("R6 leg%0d complement coverage", leg), hi + lo, 2 * P - D);
    endtask

    // Per-cycle monitor: overlap, dead gap, strobe spacing and period windows.
    always @(negedge clk) begin
        if (run_mon) begin
            if (gh1 && gl1) ovl++;
            if (gh2 && gl2) ovl++;
            if (gl1 && !gl1_p && h1_off < D) gap_err++;
            if (gh1 && !gh1_p && l1_off < D) gap_err++;
            if (gl2 && !gl2_p && h2_off < D) gap_err++;
            if (gh2 && !gh2_p && l2_off < D) gap_err++;
            h1_off = gh1 ? 0 : h1_off + 1;
            l1_off = gl1 ? 0 : l1_off + 1;
            h2_off = gh2 ? 0 : h2_off + 1;
            l2_off = gl2 ? 0 : l2_off + 1;
            gh1_p = gh1; gl1_p = gl1; gh2_p = gh2; gl2_p = gl2;
            since++;
            if (strobe) begin
                strobes++;
                if (armed) chk(since == 2 * P, "R1 strobe spacing", since, 2 * P);
                armed = 1'b1;
                since = 0;
                if (win_valid) begin
                    eval_leg(1, hi1, lo1);
                    eval_leg(2, hi2, lo2);
                end
                k_b = (k_b + 1) % N;
                if (k_b == 0) begin
                    sch_m = int'(sch_seen);
                    en_m  = en_seen;
                end
                prev_en = win_valid ? p_en : 1'b0;
                p_k = k_b; p_sch = sch_m; p_en = en_m; p_m = int'(m_seen);
                hi1 = int'(gh1); lo1 = int'(gl1); hi2 = int'(gh2); lo2 = int'(gl2);
                win_valid = 1'b1;
            end else begin
                hi1 += int'(gh1); lo1 += int'(gl1); hi2 += int'(gh2); lo2 += int'(gl2);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 180000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 180000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (5) @(posedge clk);
        #1;
        chk({gh1, gl1, gh2, gl2} == 4'b0, "R11 gates off in reset", int'({gh1, gl1, gh2, gl2}), 0);
        chk(strobe == 1'b0, "R11 strobe low in reset", int'(strobe), 0);
        rst_n = 1'b1;
        run_mon = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk({gh1, gl1, gh2, gl2} == 4'b0, "R11 gates off after reset", int'({gh1, gl1, gh2, gl2}), 0);
        enable = 1'b1;
        scheme = 2'd0;
        m = 8'd200;
        for (int f = 0; f < 28; f++) begin
            logic [1:0]    nsch;
            logic          nen;
            logic [MW-1:0] nm;
            if (f < 8) begin
                nsch = 2'(f % 4);
                nen  = (f != 5);
                nm   = (f == 2) ? 8'd0 : (f == 3 || f == 6) ? 8'd255 : 8'd200;
            end else begin
                nsch = 2'($urandom_range(0, 3));
                nen  = ($urandom_range(0, 7) != 0);
                nm   = 8'($urandom_range(0, 255));
            end
            for (int j = 0; j < 8; j++) begin
                repeat (FUND / 8 + int'($urandom_range(0, 6))) @(posedge clk);
                #1;
                if (j == 3) begin
                    scheme = nsch;
                    enable = nen;
                end
                if (f < 8) m = nm;
                else if ($urandom_range(0, 7) == 0) m = ($urandom_range(0, 1) == 1) ? 8'd255 : 8'd0;
                else m = 8'($urandom_range(0, 255));
            end
        end
        repeat (2 * FUND) @(posedge clk);
        #1;
        run_mon = 1'b0;
        chk(ovl == 0, "R6 no leg overlap", ovl, 0);
        chk(gap_err == 0, "R6 dead-time gap", gap_err, 0);
        chk(strobes > 20 * N, "R1 strobes seen", strobes, 20 * N);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule